// File: doc/BRIEF.md
# Ingress Packet Admission Checker

This block sits inside one switch input controller and rules on every arriving data packet header. For each header it decides whether the packet may enter shared memory or must be dropped. It looks at the destination bitmap, the mask of output ports that are enabled, a multicast filter mask, whether a free store address exists, the output-queue and memory grant state, and a best-effort drop condition with its enable.

The verdict arrives one clock after the header strobe. It is either an accept pulse, which carries the filtered destination bitmap forward, or a discard pulse with a reason code. When more than one drop condition holds, a fixed priority picks the reason that is reported.

Three error kinds set sticky status flags: no store address, a flow-control violation, and, in the 32-port wide arrangement, a bitmap that spans both port halves. Software clears a flag by writing 1 to it. A mask input keeps individual flags from raising the interrupt line.

Top module: `admit_checker`

## Requirements
- R1: One cycle after a cycle with `hdr_valid` high, exactly one of `accept_o` and `discard_o` is high for one cycle. Both stay low one cycle after a cycle with `hdr_valid` low.
- R2: If `dest_map & port_en` is zero, the packet is discarded with reason code 1.
- R3: If `addr_avail` is low, the packet is discarded with reason code 2, and status bit 0 is set.
- R4: If `oq_grant` or `mem_grant` is low, the packet is discarded with reason code 3, and status bit 1 is set.
- R5: If `dest_map & port_en & filt_mask` is zero, the packet is discarded with reason code 4.
- R6: If `be_en` and `be_cond` are both high, the packet is discarded with reason code 5.
- R7: If `wide_mode` is high and `dest_map` has a bit set in both the lower half and the upper half of the ports, the packet is discarded with reason code 6, and status bit 2 is set.
- R8: When several conditions hold at once, the reported reason is the lowest code among them. A status bit is set only when its own condition is the one reported.
- R9: An accepted packet shows reason code 0, and `fwd_map_o` equals `dest_map & port_en & filt_mask`. On a discard, `fwd_map_o` is zero.
- R10: Status bits are sticky. Writing 1 to a bit of `stat_clr` clears that bit at the next edge. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R11: After each clock edge, `irq_o` equals the OR of (new status AND NOT `irq_mask`), where `irq_mask` is the value sampled at that edge.
- R12: While `rst` is high at an edge, all outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header present this cycle |
| dest_map | input | NPORTS | Destination port bitmap |
| port_en | input | NPORTS | Enabled output ports |
| filt_mask | input | NPORTS | Multicast filter mask |
| wide_mode | input | 1 | 32-port arrangement; enables the half-span check |
| addr_avail | input | 1 | A free store address exists |
| oq_grant | input | 1 | Output-queue grant held |
| mem_grant | input | 1 | Memory grant held |
| be_en | input | 1 | Best-effort drop filter enabled |
| be_cond | input | 1 | Best-effort drop condition true |
| stat_clr | input | 3 | Write-1-to-clear strobe for the status bits |
| irq_mask | input | 3 | 1 masks the matching status bit |
| accept_o | output | 1 | Packet admitted |
| discard_o | output | 1 | Packet dropped |
| reason_o | output | 3 | Drop reason code, 0 on accept |
| fwd_map_o | output | NPORTS | Filtered bitmap of an admitted packet |
| status_o | output | 3 | Sticky flags: bit 0 no-address, bit 1 flow-control, bit 2 half-span |
| irq_o | output | 1 | Interrupt request |

## Verification
Random headers are drawn with skewed probabilities, so that every drop condition occurs alone and together with others. Comparing them with a reference priority function shows whether the ordering between the conditions is right. Bitmaps are built in three ways: confined to the lower half, confined to the upper half, or spanning both. These, with `wide_mode` both high and low, separate a correct span check from one that looks at the wrong half or ignores the mode. Directed cases put a set and a clear on the same status bit in one cycle, and toggle the mask, to tell the sticky and interrupt logic apart from a design that simply passes the inputs through.

// File: rtl/admit_pkg.sv
package admit_pkg;
  localparam int NSTAT   = 3;
  localparam int RSN_W   = 3;
  localparam int NREASON = 7;

  typedef enum logic [RSN_W-1:0] {
    RSN_NONE     = 3'd0,
    RSN_DISABLED = 3'd1,
    RSN_NOADDR   = 3'd2,
    RSN_FCVIOL   = 3'd3,
    RSN_EMPTY    = 3'd4,
    RSN_BESTEFF  = 3'd5,
    RSN_SPAN     = 3'd6
  } reason_e;

  localparam int ST_NOADDR = 0;
  localparam int ST_FCVIOL = 1;
  localparam int ST_SPAN   = 2;
endpackage

// File: rtl/admit_filter.sv
module admit_filter #(
  parameter int NPORTS = 32
) (
  input  logic [NPORTS-1:0] dest_map,
  input  logic [NPORTS-1:0] port_en,
  input  logic [NPORTS-1:0] filt_mask,
  input  logic              wide_mode,
  output logic [NPORTS-1:0] fwd_map,
  output logic              none_enabled,
  output logic              filt_empty,
  output logic              span_err
);
  localparam int HALF = NPORTS / 2;

  logic [NPORTS-1:0] enabled_map;
  logic              lo_hit;
  logic              hi_hit;

  always_comb begin
    enabled_map  = dest_map & port_en;
    fwd_map      = enabled_map & filt_mask;
    none_enabled = (enabled_map == '0);
    filt_empty   = (fwd_map == '0);
    lo_hit       = |dest_map[HALF-1:0];
    hi_hit       = |dest_map[NPORTS-1:HALF];
    span_err     = wide_mode && lo_hit && hi_hit;
  end
endmodule

// File: rtl/admit_arbiter.sv
module admit_arbiter
  import admit_pkg::*;
(
  input  logic [NREASON-1:1] cond,
  output reason_e            reason,
  output logic               drop
);
  always_comb begin
    reason = RSN_NONE;
    for (int i = NREASON - 1; i >= 1; i--) begin
      if (cond[i]) reason = reason_e'(i);
    end
    drop = (reason != RSN_NONE);
  end
endmodule

// File: rtl/admit_status.sv
module admit_status
  import admit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTAT-1:0] set_vec,
  input  logic [NSTAT-1:0] clr_vec,
  input  logic [NSTAT-1:0] irq_mask,
  output logic [NSTAT-1:0] status,
  output logic             irq
);
  logic [NSTAT-1:0] status_d;

  for (genvar g = 0; g < NSTAT; g++) begin : g_bit
    assign status_d[g] = set_vec[g] | (status[g] & ~clr_vec[g]);

    always_ff @(posedge clk) begin
      if (rst) status[g] <= 1'b0;
      else     status[g] <= status_d[g];
    end

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      (status[g] && !clr_vec[g]) |=> status[g]);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_vec[g] |=> status[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status_d & ~irq_mask);
  end

  a_r11_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));
endmodule

// File: rtl/admit_checker.sv
module admit_checker
  import admit_pkg::*;
#(
  parameter int NPORTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [NPORTS-1:0] dest_map,
  input  logic [NPORTS-1:0] port_en,
  input  logic [NPORTS-1:0] filt_mask,
  input  logic              wide_mode,
  input  logic              addr_avail,
  input  logic              oq_grant,
  input  logic              mem_grant,
  input  logic              be_en,
  input  logic              be_cond,
  input  logic [2:0]        stat_clr,
  input  logic [2:0]        irq_mask,
  output logic              accept_o,
  output logic              discard_o,
  output logic [2:0]        reason_o,
  output logic [NPORTS-1:0] fwd_map_o,
  output logic [2:0]        status_o,
  output logic              irq_o
);
  logic [NPORTS-1:0]  fwd_map;
  logic               none_enabled;
  logic               filt_empty;
  logic               span_err;
  logic [NREASON-1:1] cond;
  reason_e            reason;
  logic               drop;
  logic [NSTAT-1:0]   set_vec;

  admit_filter #(.NPORTS(NPORTS)) u_filter (
    .dest_map     (dest_map),
    .port_en      (port_en),
    .filt_mask    (filt_mask),
    .wide_mode    (wide_mode),
    .fwd_map      (fwd_map),
    .none_enabled (none_enabled),
    .filt_empty   (filt_empty),
    .span_err     (span_err)
  );

  always_comb begin
    cond               = '0;
    cond[RSN_DISABLED] = none_enabled;
    cond[RSN_NOADDR]   = !addr_avail;
    cond[RSN_FCVIOL]   = !(oq_grant && mem_grant);
    cond[RSN_EMPTY]    = filt_empty;
    cond[RSN_BESTEFF]  = be_en && be_cond;
    cond[RSN_SPAN]     = span_err;
  end

  admit_arbiter u_arb (
    .cond   (cond),
    .reason (reason),
    .drop   (drop)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_NOADDR] = hdr_valid && (reason == RSN_NOADDR);
    set_vec[ST_FCVIOL] = hdr_valid && (reason == RSN_FCVIOL);
    set_vec[ST_SPAN]   = hdr_valid && (reason == RSN_SPAN);
  end

  admit_status u_status (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_vec  (stat_clr),
    .irq_mask (irq_mask),
    .status   (status_o),
    .irq      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_o  <= 1'b0;
      discard_o <= 1'b0;
      reason_o  <= '0;
      fwd_map_o <= '0;
    end else begin
      accept_o  <= hdr_valid && !drop;
      discard_o <= hdr_valid && drop;
      reason_o  <= hdr_valid ? reason : RSN_NONE;
      fwd_map_o <= (hdr_valid && !drop) ? fwd_map : '0;
    end
  end

  a_r1_one_verdict: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> (accept_o ^ discard_o));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !(accept_o || discard_o));
  a_r9_accept_reason: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> (reason_o == 3'd0 && fwd_map_o != '0));
  a_r9_discard_reason: assert property (@(posedge clk) disable iff (rst)
    discard_o |-> (reason_o != 3'd0 && fwd_map_o == '0));
  a_r3_noaddr_flag: assert property (@(posedge clk) disable iff (rst)
    (discard_o && reason_o == 3'd2) |-> status_o[0]);
  a_r4_fc_flag: assert property (@(posedge clk) disable iff (rst)
    (discard_o && reason_o == 3'd3) |-> status_o[1]);
  a_r7_span_flag: assert property (@(posedge clk) disable iff (rst)
    (discard_o && reason_o == 3'd6) |-> status_o[2]);
endmodule

// File: tb/admit_checker_tb.sv
module admit_checker_tb;
  localparam int NP = 32;
  localparam int HP = NP / 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          hdr_valid;
  logic [NP-1:0] dest_map, port_en, filt_mask;
  logic          wide_mode, addr_avail, oq_grant, mem_grant, be_en, be_cond;
  logic [2:0]    stat_clr, irq_mask;
  logic          accept_o, discard_o, irq_o;
  logic [2:0]    reason_o, status_o;
  logic [NP-1:0] fwd_map_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] exp_stat = '0;
  logic       exp_irq = 1'b0;

  always #5 clk = ~clk;

  admit_checker #(.NPORTS(NP)) u_dut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .dest_map(dest_map),
    .port_en(port_en), .filt_mask(filt_mask), .wide_mode(wide_mode),
    .addr_avail(addr_avail), .oq_grant(oq_grant), .mem_grant(mem_grant),
    .be_en(be_en), .be_cond(be_cond), .stat_clr(stat_clr), .irq_mask(irq_mask),
    .accept_o(accept_o), .discard_o(discard_o), .reason_o(reason_o),
    .fwd_map_o(fwd_map_o), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [2:0] ref_reason();
    logic [NP-1:0] en = dest_map & port_en;
    if (en == '0) return 3'd1;
    if (!addr_avail) return 3'd2;
    if (!(oq_grant && mem_grant)) return 3'd3;
    if ((en & filt_mask) == '0) return 3'd4;
    if (be_en && be_cond) return 3'd5;
    if (wide_mode && (|dest_map[HP-1:0]) && (|dest_map[NP-1:HP])) return 3'd6;
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive current inputs for one edge, then compare everything with the model.
  task automatic step(input string req);
    logic [2:0]    r = ref_reason();
    logic [NP-1:0] fm = dest_map & port_en & filt_mask;
    logic [2:0]    setv = '0;
    logic          acc = hdr_valid && (r == 3'd0);
    logic          dis = hdr_valid && (r != 3'd0);
    if (hdr_valid && r == 3'd2) setv[0] = 1'b1;
    if (hdr_valid && r == 3'd3) setv[1] = 1'b1;
    if (hdr_valid && r == 3'd6) setv[2] = 1'b1;
    exp_stat = setv | (exp_stat & ~stat_clr);
    exp_irq  = |(exp_stat & ~irq_mask);
    @(posedge clk); #1;
    chk({req, " R1 accept"}, 64'(accept_o), 64'(acc));
    chk({req, " R1 discard"}, 64'(discard_o), 64'(dis));
    chk({req, " R8 reason"}, 64'(reason_o), hdr_valid ? 64'(r) : 64'd0);
    chk({req, " R9 fwd_map"}, 64'(fwd_map_o), acc ? 64'(fm) : 64'd0);
    chk({req, " R10 status"}, 64'(status_o), 64'(exp_stat));
    chk({req, " R11 irq"}, 64'(irq_o), 64'(exp_irq));
    @(negedge clk);
  endtask

  task automatic clean();
    hdr_valid = 1'b1; dest_map = 32'h0000_0011; port_en = '1; filt_mask = '1;
    wide_mode = 1'b1; addr_avail = 1'b1; oq_grant = 1'b1; mem_grant = 1'b1;
    be_en = 1'b0; be_cond = 1'b0; stat_clr = '0; irq_mask = '0;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    clean(); hdr_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    // R12: reset state
    chk("R12 outputs", 64'({accept_o, discard_o, reason_o, fwd_map_o, status_o, irq_o}), 64'd0);
    rst = 1'b0;

    clean(); step("R9 clean accept");
    clean(); port_en = 32'hFFFF_FF00; step("R2 all disabled");
    clean(); addr_avail = 1'b0; step("R3 no address");
    clean(); mem_grant = 1'b0; step("R4 no mem grant");
    clean(); oq_grant = 1'b0; stat_clr = 3'b001; step("R4 no oq grant, R10 clear bit0");
    clean(); filt_mask = 32'hFFFF_FF0F; dest_map = 32'h0000_0030; filt_mask = 32'hFFFF_FFCF;
    step("R5 filtered empty");
    clean(); be_en = 1'b1; be_cond = 1'b1; step("R6 best effort");
    clean(); be_cond = 1'b1; step("R6 filter off");
    clean(); dest_map = 32'h0001_0001; step("R7 span");
    clean(); dest_map = 32'h0001_0001; wide_mode = 1'b0; step("R7 narrow no span");
    // R8: every condition at once -> code 1
    clean(); port_en = '0; addr_avail = 1'b0; oq_grant = 1'b0; be_en = 1'b1; be_cond = 1'b1;
    dest_map = 32'h8000_0001; step("R8 all conditions");
    clean(); addr_avail = 1'b0; oq_grant = 1'b0; step("R8 noaddr over fc");
    // R10: set and clear of bit 0 in the same cycle -> set wins
    clean(); addr_avail = 1'b0; stat_clr = 3'b001; step("R10 set wins");
    clean(); hdr_valid = 1'b0; irq_mask = 3'b111; step("R11 masked");
    clean(); hdr_valid = 1'b0; irq_mask = 3'b011; step("R11 partial mask");
    clean(); hdr_valid = 1'b0; stat_clr = 3'b111; step("R10 clear all");
    clean(); hdr_valid = 1'b0; step("R1 idle");

    for (int i = 0; i < 400; i++) begin
      int shape;
      clean();
      hdr_valid  = ($urandom % 8) != 0;
      shape      = $urandom % 3;
      dest_map   = 32'($urandom) & 32'($urandom);
      if (shape == 0) dest_map[NP-1:HP] = '0;
      else if (shape == 1) dest_map[HP-1:0] = '0;
      port_en    = (($urandom % 4) == 0) ? 32'($urandom) : '1;
      filt_mask  = (($urandom % 4) == 0) ? 32'($urandom) & 32'($urandom) : '1;
      wide_mode  = $urandom % 2;
      addr_avail = ($urandom % 8) != 0;
      oq_grant   = ($urandom % 8) != 0;
      mem_grant  = ($urandom % 8) != 0;
      be_en      = $urandom % 2;
      be_cond    = ($urandom % 4) == 0;
      stat_clr   = (($urandom % 6) == 0) ? 3'($urandom) : 3'd0;
      irq_mask   = 3'($urandom);
      step("R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule